// File: doc/BRIEF.md
# Integer Flag and Condition Field Update Unit

This block sits after an integer adder-type datapath and keeps the architectural
status bits of the fixed-point exception register: carry (CA), 32-bit carry
(CA32), overflow (OV) and sticky summary overflow (SO). It also keeps the 4-bit
condition field CR0. Each cycle, the issuing stage presents the two source
operands, an optional immediate and the 64-bit result, along with a valid strobe
and three independent enables: carry, overflow and record. The block computes
the new flags from the operands and the result and registers them on the clock
edge.

Carry is found by an unsigned comparison of every operand against the result.
The comparison is done at full width and again on the low half-word. Overflow
comes from the sign relation of the first two operands and the result. SO
gathers overflow until software rewrites the register through the load port.
With record enabled, CR0 receives the signed classification of the result
together with the current SO.

Top module: `int_flag_unit`

## Requirements
- R1: A synchronous reset clears CA, CA32, OV, SO and CR0 to zero.
- R2: When `inv_first` is set, the first operand is bitwise inverted before it is used in any carry or overflow evaluation.
- R3: With `carry_en`, CA becomes 1 when any operand is unsigned-greater than the full-width result, and 0 otherwise. The first operand (after R2), the second operand and, when `imm_valid` is set, the immediate all take part.
- R4: With `carry_en`, CA32 follows the rule of R3 applied to the low 32 bits of every operand and of the result.
- R5: With `ovf_en`, OV becomes 1 when the first operand (after R2) and the second operand have equal sign bits and the result's sign bit differs from them, and 0 otherwise. The immediate never takes part.
- R6: With `ovf_en`, SO becomes SO OR the new OV. No operation clears SO.
- R7: With `rec_en`, CR0 is loaded as {negative, positive, zero, SO} from bit 3 down to bit 0. The result is read as signed, and the SO used is the value after any overflow update in the same operation.
- R8: A flag group whose enable is low keeps its value. When `valid` is low, nothing changes.
- R9: When `xer_wr` is high, the exception bits are loaded from `xer_wdata` as SO=bit 3, OV=bit 2, CA32=bit 1, CA=bit 0. This load takes priority over a valid operation in the same cycle, and CR0 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Operation strobe |
| inv_first | input | 1 | Invert first operand |
| imm_valid | input | 1 | Immediate takes part in carry |
| imm_data | input | 64 | Immediate operand |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| result | input | 64 | Datapath result |
| carry_en | input | 1 | Update CA and CA32 |
| ovf_en | input | 1 | Update OV and SO |
| rec_en | input | 1 | Update CR0 |
| xer_wr | input | 1 | Software load of exception bits |
| xer_wdata | input | 4 | Load value {SO,OV,CA32,CA} |
| ca | output | 1 | Carry |
| ca32 | output | 1 | 32-bit carry |
| ov | output | 1 | Overflow |
| so | output | 1 | Summary overflow |
| cr0 | output | 4 | Condition field {neg,pos,zero,so} |

## Verification
Operands are drawn at random from a pool of boundary values: zero, all ones, the two sign extremes, the half-word edges, and arbitrary words. Results are either a true sum or unrelated values. This makes both carry widths disagree often, and it produces all three sign classes of the result. Directed cases separate the effect of inversion from that of the immediate. They also show a sticky SO surviving an overflow-free operation, and a same-cycle overflow showing up in CR0. Finally, they show the software load winning over a concurrent operation.

// File: rtl/int_flag_unit.sv
module int_flag_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            inv_first,
  input  logic            imm_valid,
  input  logic [XLEN-1:0] imm_data,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] result,
  input  logic            carry_en,
  input  logic            ovf_en,
  input  logic            rec_en,
  input  logic            xer_wr,
  input  logic [3:0]      xer_wdata,
  output logic            ca,
  output logic            ca32,
  output logic            ov,
  output logic            so,
  output logic [3:0]      cr0
);
  localparam int HALF = XLEN / 2;
  localparam int MSB  = XLEN - 1;

  logic [XLEN-1:0] opa;
  logic            ca_n, ca32_n, ov_n, so_n;
  logic            neg, zero, pos;

  assign opa = inv_first ? ~src_a : src_a;

  assign ca_n = (opa > result) || (src_b > result) ||
                (imm_valid && (imm_data > result));

  assign ca32_n = (opa[HALF-1:0] > result[HALF-1:0]) ||
                  (src_b[HALF-1:0] > result[HALF-1:0]) ||
                  (imm_valid && (imm_data[HALF-1:0] > result[HALF-1:0]));

  assign ov_n = (opa[MSB] == src_b[MSB]) && (result[MSB] != opa[MSB]);
  assign so_n = ovf_en ? (so | ov_n) : so;

  assign neg  = result[MSB];
  assign zero = (result == '0);
  assign pos  = !neg && !zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      ca   <= 1'b0;
      ca32 <= 1'b0;
      ov   <= 1'b0;
      so   <= 1'b0;
      cr0  <= 4'b0;
    end else if (xer_wr) begin
      so   <= xer_wdata[3];
      ov   <= xer_wdata[2];
      ca32 <= xer_wdata[1];
      ca   <= xer_wdata[0];
    end else if (valid) begin
      if (carry_en) begin
        ca   <= ca_n;
        ca32 <= ca32_n;
      end
      if (ovf_en) begin
        ov <= ov_n;
        so <= so_n;
      end
      if (rec_en)
        cr0 <= {neg, pos, zero, so_n};
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!valid && !xer_wr) |=> $stable({ca, ca32, ov, so, cr0}));

  p_carry_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && !carry_en && !xer_wr) |=> $stable({ca, ca32}));

  p_so_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (so && !xer_wr) |=> so);

  p_ov_implies_so_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && ovf_en && !xer_wr) |=> (!ov || so));

  p_cr0_class_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && rec_en && !xer_wr) |=> ($countones(cr0[3:1]) == 1));

  p_cr0_so_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && rec_en && !xer_wr) |=> (cr0[0] == so));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    xer_wr |=> ({so, ov, ca32, ca} == $past(xer_wdata)));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> ({ca, ca32, ov, so, cr0} == 8'h00));
endmodule

// File: tb/int_flag_unit_test.sv
module int_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid, inv_first, imm_valid, carry_en, ovf_en, rec_en, xer_wr;
  logic [63:0] imm_data, src_a, src_b, result;
  logic [3:0]  xer_wdata;
  logic        ca, ca32, ov, so;
  logic [3:0]  cr0;

  int n_chk = 0;
  int n_bad = 0;
  logic m_ca, m_ca32, m_ov, m_so;
  logic [3:0] m_cr0;

  always #4 clk = ~clk;

  int_flag_unit uut (
    .clk(clk), .rst(rst), .valid(valid), .inv_first(inv_first),
    .imm_valid(imm_valid), .imm_data(imm_data), .src_a(src_a), .src_b(src_b),
    .result(result), .carry_en(carry_en), .ovf_en(ovf_en), .rec_en(rec_en),
    .xer_wr(xer_wr), .xer_wdata(xer_wdata),
    .ca(ca), .ca32(ca32), .ov(ov), .so(so), .cr0(cr0));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 ca"},   {3'b0, ca},   {3'b0, m_ca});
    chk({tag, " R4 ca32"}, {3'b0, ca32}, {3'b0, m_ca32});
    chk({tag, " R5 ov"},   {3'b0, ov},   {3'b0, m_ov});
    chk({tag, " R6 so"},   {3'b0, so},   {3'b0, m_so});
    chk({tag, " R7 cr0"},  cr0,          m_cr0);
  endtask

  function automatic logic gt(input logic [63:0] x, input logic [63:0] y, input bit low);
    if (low) return x[31:0] > y[31:0];
    return x > y;
  endfunction

  task automatic model;
    logic [63:0] a;
    logic o, s;
    if (xer_wr) begin
      {m_so, m_ov, m_ca32, m_ca} = xer_wdata;
      return;
    end
    if (!valid) return;
    a = inv_first ? ~src_a : src_a;
    if (carry_en) begin
      m_ca   = gt(a, result, 0) | gt(src_b, result, 0) | (imm_valid & gt(imm_data, result, 0));
      m_ca32 = gt(a, result, 1) | gt(src_b, result, 1) | (imm_valid & gt(imm_data, result, 1));
    end
    o = (a[63] == src_b[63]) && (result[63] != a[63]);
    s = m_so;
    if (ovf_en) begin
      m_ov = o;
      s = m_so | o;
      m_so = s;
    end
    if (rec_en)
      m_cr0 = {$signed(result) < 0, $signed(result) > 0, result == 0, s};
  endtask

  task automatic idle;
    valid = 0; inv_first = 0; imm_valid = 0; carry_en = 0; ovf_en = 0;
    rec_en = 0; xer_wr = 0; xer_wdata = 0; imm_data = 0;
    src_a = 0; src_b = 0; result = 0;
  endtask

  task automatic cycle(input string tag);
    model();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] r,
                    input logic inv, input logic iv, input logic [63:0] imm,
                    input logic ce, input logic oe, input logic re);
    idle();
    valid = 1; src_a = a; src_b = b; result = r; inv_first = inv;
    imm_valid = iv; imm_data = imm; carry_en = ce; ovf_en = oe; rec_en = re;
  endtask

  function automatic logic [63:0] pick;
    case ($urandom % 8)
      0: return 64'h0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'h0000_0000_FFFF_FFFF;
      5: return 64'h0000_0001_0000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst = 1;
    {m_ca, m_ca32, m_ov, m_so} = 0; m_cr0 = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst = 0;

    op(64'h0, 64'h0, 64'h0, 0, 0, 0, 1, 0, 0); cycle("R2 no-invert");
    op(64'h0, 64'h0, 64'h0, 1, 0, 0, 1, 0, 0); cycle("R2 invert");
    op(64'h0, 64'h5, 64'h5, 0, 1, 64'h6, 1, 0, 0); cycle("R3 immediate");
    op(64'h0, 64'h5, 64'h5, 0, 0, 64'h6, 1, 0, 0); cycle("R3 no immediate");
    op(64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0000_0001_0000_0000, 0, 0, 0, 1, 0, 0); cycle("R4 low carry");
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 1, 1); cycle("R7 same-cycle so");
    op(64'h1, 64'h1, 64'h2, 0, 0, 0, 0, 1, 1); cycle("R6 sticky");
    op(64'h1, 64'h1, 64'h0, 0, 0, 0, 0, 0, 0); cycle("R8 all off");
    idle(); cycle("R8 invalid");
    idle(); carry_en = 1; ovf_en = 1; rec_en = 1; result = 64'h0; src_a = '1; cycle("R8 enables no valid");
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 0, 0, 0, 1, 1, 1);
    xer_wr = 1; xer_wdata = 4'b0000; cycle("R9 load wins");
    idle(); xer_wr = 1; xer_wdata = 4'b1010; cycle("R9 load pattern");
    op(64'h5, 64'h3, 64'h2, 0, 1, 64'h9, 0, 1, 0); cycle("R5 immediate excluded");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b, r;
      a = pick(); b = pick();
      r = ($urandom % 2) ? a + b : pick();
      op(a, b, r, 1'($urandom), 1'($urandom), pick(),
         1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 20 == 0) begin xer_wr = 1; xer_wdata = 4'($urandom); end
      if ($urandom % 10 == 0) valid = 0;
      cycle("random");
    end

    idle(); rst = 1;
    {m_ca, m_ca32, m_ov, m_so} = 0; m_cr0 = 0;
    @(negedge clk);
    check_all("R1 reset again");
    finish_run();
  end
endmodule